// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit arithmetic and logic unit of a small accumulator-style processor. The working register W is always one operand. The second operand is chosen per operation: a byte read from the register file, an immediate constant, or W itself. Single-operand operations act only on the chosen operand. The supported operations are add, subtract, rotate left or right through carry, AND, inclusive OR, exclusive OR, complement, increment, decrement, clear and move.

Each accepted operation produces an 8-bit result. It also updates the Carry, Digit Carry and Zero status flags, but only the flags that belong to that operation. A destination bit decides where the result goes. When the bit is set, the result is written into W. When it is clear, the result is handed back with a write-back strobe, so that the surrounding core can store it in the register file. W cannot be addressed as a file register. Its value is visible only on a dedicated output.

All outputs are registered. An operation presented with `valid_i` high at one rising edge shows its result, new flags and new W right after that edge. A following operation therefore sees the updated W and Carry with no stall.

Top module: `acc_alu`

## Requirements
- R1: During and right after synchronous reset, W is 0, C, DC and Z are 0, and `res_vld_o` and `wb_o` are low.
- R2: Add (opcode 1) gives (W + operand) mod 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set exactly when the result is 0.
- R3: Subtract (opcode 2) gives (operand − W) mod 256, computed as operand plus the two's complement of W. C is 1 when there is no borrow out of bit 7. DC is 1 when there is no borrow out of bit 3. Z marks a zero result.
- R4: Move (0), AND (3), OR (4), XOR (5) and complement (6) update only Z. C and DC keep their values.
- R5: Increment (7) and decrement (8) wrap modulo 256 and update only Z.
- R6: Clear (11) gives 0 and sets Z. C and DC keep their values.
- R7: Rotate left (9) gives {operand[6:0], C} and loads C from operand bit 7. Rotate right (10) gives {C, operand[7:1]} and loads C from operand bit 0. Both leave Z and DC unchanged.
- R8: Operand select `src_i`: when bit 1 is set the operand is W. Otherwise bit 0 = 1 selects `lit_i` and bit 0 = 0 selects `file_i`.
- R9: With `dest_w_i` = 1 the result is written to W and `wb_o` stays low. With `dest_w_i` = 0, `wb_o` pulses for one cycle with the result on `res_o`, and W is unchanged.
- R10: Latency is one cycle. W and the flags change on the same edge as the result, so back-to-back operations use the updated W and C.
- R11: Opcodes 12 to 15 are reserved. They return the operand on `res_o` with `res_vld_o` high, but leave W and all flags unchanged and never raise `wb_o`.
- R12: While `valid_i` is low, `res_vld_o` and `wb_o` are low, and W and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation accepted at this edge |
| op_i | input | 4 | Operation code |
| src_i | input | 2 | Operand select: bit 1 selects W, otherwise bit 0 selects the literal over the file byte |
| file_i | input | 8 | Register-file byte |
| lit_i | input | 8 | Immediate constant |
| dest_w_i | input | 1 | 1: write result to W; 0: return result for write-back |
| res_o | output | 8 | Result |
| res_vld_o | output | 1 | Result valid, one cycle after an accepted operation |
| wb_o | output | 1 | Write-back strobe toward the register file |
| w_o | output | 8 | Current working register |
| c_o | output | 1 | Carry flag |
| dc_o | output | 1 | Digit carry flag |
| z_o | output | 1 | Zero flag |

## Verification
The hardest situation to reach is a flag that must survive a chain of operations that do not own it. Examples are a DC value left by a subtract that has to outlive a rotate and several logic operations, or a Carry set by a rotate that has to pass unchanged through a clear. Directed sequences set up such a flag on purpose, apply the non-owning operations back to back, and then consume the flag with a rotate, whose result exposes it. A long pseudo-random run of mixed opcodes, operand sources and destinations then compares every result, W and flag against an independent model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_MOV = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_AND = 4'd3,
    OP_IOR = 4'd4,
    OP_XOR = 4'd5,
    OP_CMP = 4'd6,
    OP_INC = 4'd7,
    OP_DEC = 4'd8,
    OP_RLC = 4'd9,
    OP_RRC = 4'd10,
    OP_CLR = 4'd11
  } op_e;

  localparam logic [OPW-1:0] OP_FIRST_RSV = 4'd12;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } flag_t;

endpackage

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] w,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output flag_t         nf,
  output flag_t         upd,
  output logic          legal
);
  localparam int HW = DW / 2;

  logic [DW:0]   add_s;
  logic [DW:0]   sub_s;
  logic [DW-1:0] w_n;

  assign w_n   = ~w;
  assign add_s = {1'b0, w} + {1'b0, b};
  assign sub_s = {1'b0, b} + {1'b0, w_n} + (DW+1)'(1);

  always_comb begin
    res    = b;
    nf.c   = cin;
    nf.dc  = 1'b0;
    upd    = '0;
    legal  = 1'b1;
    case (op)
      OP_MOV: begin res = b;                upd.z = 1'b1; end
      OP_AND: begin res = w & b;            upd.z = 1'b1; end
      OP_IOR: begin res = w | b;            upd.z = 1'b1; end
      OP_XOR: begin res = w ^ b;            upd.z = 1'b1; end
      OP_CMP: begin res = ~b;               upd.z = 1'b1; end
      OP_INC: begin res = b + DW'(1);       upd.z = 1'b1; end
      OP_DEC: begin res = b - DW'(1);       upd.z = 1'b1; end
      OP_CLR: begin res = '0;               upd.z = 1'b1; end
      OP_ADD: begin
        res   = add_s[DW-1:0];
        nf.c  = add_s[DW];
        nf.dc = add_s[HW] ^ w[HW] ^ b[HW];
        upd   = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      end
      OP_SUB: begin
        res   = sub_s[DW-1:0];
        nf.c  = sub_s[DW];
        nf.dc = sub_s[HW] ^ w_n[HW] ^ b[HW];
        upd   = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      end
      OP_RLC: begin
        res   = {b[DW-2:0], cin};
        nf.c  = b[DW-1];
        upd.c = 1'b1;
      end
      OP_RRC: begin
        res   = {cin, b[DW-1:1]};
        nf.c  = b[0];
        upd.c = 1'b1;
      end
      default: begin
        res   = b;
        legal = 1'b0;
      end
    endcase
    nf.z = (res == '0);
  end

endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status
  import acc_alu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  flag_t upd,
  input  flag_t nf,
  output flag_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      if (upd.c)  q.c  <= nf.c;
      if (upd.dc) q.dc <= nf.dc;
      if (upd.z)  q.z  <= nf.z;
    end
  end
endmodule

// File: rtl/acc_alu_wreg.sv
module acc_alu_wreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [1:0]    src_i,
  input  logic [DW-1:0] file_i,
  input  logic [DW-1:0] lit_i,
  input  logic          dest_w_i,
  output logic [DW-1:0] res_o,
  output logic          res_vld_o,
  output logic          wb_o,
  output logic [DW-1:0] w_o,
  output logic          c_o,
  output logic          dc_o,
  output logic          z_o
);
  op_e           op_d;
  logic [DW-1:0] opnd;
  logic [DW-1:0] res_c;
  flag_t         nf_c;
  flag_t         upd_c;
  flag_t         flg_q;
  logic          legal_c;
  logic          w_we;

  assign op_d = op_e'(op_i);
  assign opnd = src_i[1] ? w_o : (src_i[0] ? lit_i : file_i);

  acc_alu_core #(.DW(DW)) u_core (
    .op    (op_d),
    .w     (w_o),
    .b     (opnd),
    .cin   (flg_q.c),
    .res   (res_c),
    .nf    (nf_c),
    .upd   (upd_c),
    .legal (legal_c)
  );

  acc_alu_status u_status (
    .clk (clk),
    .rst (rst),
    .en  (valid_i),
    .upd (upd_c),
    .nf  (nf_c),
    .q   (flg_q)
  );

  assign w_we = valid_i && legal_c && dest_w_i;

  acc_alu_wreg #(.DW(DW)) u_wreg (
    .clk (clk),
    .rst (rst),
    .we  (w_we),
    .d   (res_c),
    .q   (w_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      res_vld_o <= 1'b0;
      wb_o      <= 1'b0;
    end else begin
      res_vld_o <= valid_i;
      wb_o      <= valid_i && legal_c && !dest_w_i;
      if (valid_i) res_o <= res_c;
    end
  end

  assign c_o  = flg_q.c;
  assign dc_o = flg_q.dc;
  assign z_o  = flg_q.z;

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (!res_vld_o && !wb_o && w_o == '0 && !c_o && !dc_o && !z_o)); // R1

  AST_SUB_EQUAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == OP_SUB && opnd == w_o)
    |=> (z_o && c_o && dc_o && res_o == '0)); // R3

  AST_ZONLY_KEEPS_C: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (op_i == OP_MOV || op_i == OP_AND || op_i == OP_IOR ||
                 op_i == OP_XOR || op_i == OP_CMP || op_i == OP_INC ||
                 op_i == OP_DEC || op_i == OP_CLR))
    |=> ($stable(c_o) && $stable(dc_o))); // R4

  AST_CLEAR_SETS_Z: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == OP_CLR) |=> (z_o && res_o == '0)); // R6

  AST_ROT_KEEPS_Z: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (op_i == OP_RLC || op_i == OP_RRC))
    |=> ($stable(z_o) && $stable(dc_o))); // R7

  AST_WB_LEAVES_W: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !dest_w_i && op_i < OP_FIRST_RSV)
    |=> (wb_o && $stable(w_o))); // R9

  AST_RSV_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i >= OP_FIRST_RSV)
    |=> (!wb_o && res_vld_o && $stable(w_o) && $stable({c_o, dc_o, z_o}))); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !valid_i
    |=> (!res_vld_o && !wb_o && $stable(w_o) && $stable({c_o, dc_o, z_o}))); // R12

endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;

  typedef struct {
    logic [7:0] res;
    logic       wb;
    logic [7:0] w;
    logic       c;
    logic       dc;
    logic       z;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [1:0] src_i = '0;
  logic [7:0] file_i = '0;
  logic [7:0] lit_i = '0;
  logic       dest_w_i = 1'b0;
  logic [7:0] res_o;
  logic       res_vld_o;
  logic       wb_o;
  logic [7:0] w_o;
  logic       c_o, dc_o, z_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  item_t sb[$];

  logic [7:0] w_m = '0;
  logic       c_m = 1'b0, dc_m = 1'b0, z_m = 1'b0;

  always #4 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .src_i(src_i),
    .file_i(file_i), .lit_i(lit_i), .dest_w_i(dest_w_i),
    .res_o(res_o), .res_vld_o(res_vld_o), .wb_o(wb_o), .w_o(w_o),
    .c_o(c_o), .dc_o(dc_o), .z_o(z_o)
  );

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // driver: model from the requirements, push expectation, present operation
  task automatic drive(input logic [3:0] op, input logic [1:0] src, input logic [7:0] f,
                       input logic [7:0] l, input bit dw, input string tag);
    logic [7:0] b, r;
    logic       nc, ndc, nz, legal;
    int         t;
    item_t      it;
    b = src[1] ? w_m : (src[0] ? l : f);
    nc = c_m; ndc = dc_m; nz = z_m; legal = 1'b1;
    case (op)
      4'd0: begin r = b; nz = (r == 0); end
      4'd1: begin
        t = int'(w_m) + int'(b); r = t[7:0]; nc = (t > 255);
        ndc = ((int'(w_m) % 16) + (int'(b) % 16)) > 15; nz = (r == 0);
      end
      4'd2: begin
        r = b - w_m; nc = (b >= w_m); ndc = (b[3:0] >= w_m[3:0]); nz = (r == 0);
      end
      4'd3: begin r = w_m & b; nz = (r == 0); end
      4'd4: begin r = w_m | b; nz = (r == 0); end
      4'd5: begin r = w_m ^ b; nz = (r == 0); end
      4'd6: begin r = ~b; nz = (r == 0); end
      4'd7: begin r = b + 8'd1; nz = (r == 0); end
      4'd8: begin r = b - 8'd1; nz = (r == 0); end
      4'd9: begin r = {b[6:0], c_m}; nc = b[7]; end
      4'd10: begin r = {c_m, b[7:1]}; nc = b[0]; end
      4'd11: begin r = 8'd0; nz = 1'b1; end
      default: begin r = b; legal = 1'b0; end
    endcase
    c_m = nc; dc_m = ndc; z_m = nz;
    if (legal && dw) w_m = r;
    it.res = r; it.wb = legal && !dw; it.w = w_m;
    it.c = c_m; it.dc = dc_m; it.z = z_m; it.tag = tag;
    sb.push_back(it);
    op_i = op; src_i = src; file_i = f; lit_i = l; dest_w_i = dw; valid_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    valid_i = 1'b0;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!res_vld_o && !wb_o && w_o == w_m && {c_o, dc_o, z_o} == {c_m, dc_m, z_m}, tag,
          $sformatf("vld=%0b wb=%0b w=%02h f=%03b", res_vld_o, wb_o, w_o, {c_o, dc_o, z_o}),
          $sformatf("vld=0 wb=0 w=%02h f=%03b", w_m, {c_m, dc_m, z_m}));
    end
  endtask

  // monitor: pop expectations as results appear
  always @(negedge clk) begin
    if (!rst && res_vld_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R10 unexpected result", $sformatf("res=%02h", res_o), "none");
      end else begin
        item_t e;
        e = sb.pop_front();
        chk(res_o == e.res && wb_o == e.wb && w_o == e.w &&
            c_o == e.c && dc_o == e.dc && z_o == e.z, e.tag,
            $sformatf("res=%02h wb=%0b w=%02h c=%0b dc=%0b z=%0b",
                      res_o, wb_o, w_o, c_o, dc_o, z_o),
            $sformatf("res=%02h wb=%0b w=%02h c=%0b dc=%0b z=%0b",
                      e.res, e.wb, e.w, e.c, e.dc, e.z));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    chk(!res_vld_o && !wb_o && w_o == 8'h00 && !c_o && !dc_o && !z_o, "R1 reset",
        $sformatf("vld=%0b wb=%0b w=%02h f=%03b", res_vld_o, wb_o, w_o, {c_o, dc_o, z_o}),
        "vld=0 wb=0 w=00 f=000");
    rst = 1'b0;
    @(negedge clk);
    chk(!res_vld_o && w_o == 8'h00, "R1 after release",
        $sformatf("vld=%0b w=%02h", res_vld_o, w_o), "vld=0 w=00");

    // R8 literal source into W, R9 dest W
    drive(4'd0, 2'b01, 8'h00, 8'h0F, 1'b1, "R8 move literal to W");
    // R2 adds
    drive(4'd1, 2'b00, 8'h01, 8'h00, 1'b1, "R2 add nibble carry");   // 0F+01=10 DC=1
    drive(4'd1, 2'b01, 8'h00, 8'hF0, 1'b1, "R2 add carry and zero"); // 10+F0=00 C=1 Z=1
    drive(4'd0, 2'b01, 8'h00, 8'h7F, 1'b1, "R4 move keeps C DC");
    drive(4'd1, 2'b01, 8'h00, 8'h01, 1'b0, "R2 add to file, R9");    // 80, wb
    // R3 subtracts, W=7F
    drive(4'd2, 2'b00, 8'h7F, 8'h00, 1'b0, "R3 sub equal");          // 00 C=1 DC=1 Z=1
    drive(4'd2, 2'b00, 8'h7D, 8'h00, 1'b0, "R3 sub borrow");         // FE C=0 DC=0
    drive(4'd0, 2'b01, 8'h00, 8'h01, 1'b1, "R8 load W 01");
    drive(4'd2, 2'b00, 8'h10, 8'h00, 1'b1, "R3 sub nibble borrow");  // 0F C=1 DC=0
    drive(4'd2, 2'b10, 8'h00, 8'h00, 1'b0, "R3 R8 sub W from W");    // 00 C=1 DC=1 Z=1
    // R4 logic
    drive(4'd3, 2'b01, 8'h00, 8'hF0, 1'b0, "R4 and zero");
    drive(4'd4, 2'b00, 8'hA0, 8'h00, 1'b1, "R4 or to W");            // AF
    drive(4'd5, 2'b01, 8'h00, 8'hAF, 1'b0, "R4 xor zero");
    drive(4'd6, 2'b10, 8'h00, 8'h00, 1'b1, "R4 complement W");       // 50
    // R5 inc/dec wrap
    drive(4'd7, 2'b00, 8'hFF, 8'h00, 1'b0, "R5 inc wrap");
    drive(4'd8, 2'b01, 8'h00, 8'h00, 1'b0, "R5 dec wrap");
    drive(4'd8, 2'b00, 8'h01, 8'h00, 1'b0, "R5 dec to zero");
    // R7 rotates through carry, C=1 DC=1 kept from sub
    drive(4'd9, 2'b00, 8'h40, 8'h00, 1'b0, "R7 rlc carry in");        // 81 C=0
    drive(4'd9, 2'b00, 8'h80, 8'h00, 1'b0, "R7 rlc carry out");       // 00 C=1 Z kept
    drive(4'd11, 2'b00, 8'h55, 8'h00, 1'b0, "R6 clear keeps C");
    drive(4'd10, 2'b10, 8'h00, 8'h00, 1'b1, "R7 rrc W carry in");     // W=50 -> A8 C=0
    drive(4'd10, 2'b00, 8'h01, 8'h00, 1'b0, "R7 rrc carry out");      // 00 C=1
    drive(4'd9, 2'b01, 8'h00, 8'h00, 1'b1, "R10 rlc uses new C");     // 01 into W
    // R11 reserved
    drive(4'd12, 2'b01, 8'h00, 8'h3C, 1'b1, "R11 reserved dest W");
    drive(4'd15, 2'b00, 8'hC3, 8'h00, 1'b0, "R11 reserved dest file");
    drive(4'd11, 2'b00, 8'h00, 8'h00, 1'b1, "R6 clear W");
    idle(4, "R12 idle quiet");

    // R10 back-to-back pseudo-random mix
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr[3:0], lfsr[5:4], lfsr[15:8], lfsr[23:16], lfsr[6], "R10 random mix");
      if (lfsr[31:29] == 3'b000) idle(1, "R12 random idle");
    end
    idle(2, "R12 final idle");
    chk(sb.size() == 0, "R10 all results seen", $sformatf("%0d", sb.size()), "0");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule